// File: doc/BRIEF.md
# Pixel Dual-Mode Hit Counter

This block is the counting logic that sits behind one pixel of a hybrid pixel detector. A discriminator output, already synchronous to the acquisition clock, marks when the charge at the pixel is above threshold. A shutter input opens and closes the acquisition window. Inside the window the block keeps two saturating counters. The 5-bit lower counter measures time over threshold. The 8-bit upper counter measures either time of arrival or the number of hits. Two further modes join the two counters into one 13-bit register. That register counts time of arrival or hits over a wider range, and no time-over-threshold value is kept in those modes.

The counting mode is chosen by a 2-bit select. The select is taken in only while the shutter is closed, so a frame is never counted under two modes. A readout strobe copies both counters to a parallel output word with a one-cycle valid flag. The same strobe clears the counters and re-arms the time-of-arrival start for the next frame.

Top module: `pix_hit_counter`

## Requirements
- R1: In modes 2'b00 and 2'b01, the lower 5-bit counter goes up by one on every clock in which disc_i is high and shutter_i is high.
- R2: In mode 2'b00, the upper 8-bit counter starts on the first rising edge of disc_i seen while shutter_i is high. It goes up by one in that clock and in every later clock with shutter_i high. Further rising edges change nothing until the next readout.
- R3: A rising edge is a clock in which disc_i is high after being low in the previous clock. In mode 2'b01 each rising edge with shutter_i high adds one to the upper counter. If disc_i is already high when the shutter opens, that does not count as an edge.
- R4: In mode 2'b10 the two counters form one 13-bit value (upper counter in bits 12:5, lower counter in bits 4:0). That value counts time of arrival by the rule of R2.
- R5: In mode 2'b11 the 13-bit value of R4 adds one for each rising edge with shutter_i high.
- R6: Counters saturate instead of wrapping: the lower counter at 31 and the upper at 255 in modes 2'b00/2'b01, and the joined value at 8191 in modes 2'b10/2'b11. In the joined modes the lower field still carries into the upper field below the limit.
- R7: While shutter_i is low, disc_i activity leaves the counters unchanged.
- R8: mode_i is registered only in clocks with shutter_i low. A change of mode_i while the shutter is open has no effect on the frame being counted.
- R9: A clock with readout_i high loads rd_data_o with {upper, lower} as held before that clock, in bits 12:5 and 4:0, and raises rd_valid_o for the next cycle. It also clears both counters and the time-of-arrival start. No count is added in that clock.
- R10: After reset, rd_data_o is 0, rd_valid_o is 0, both counters are 0 and the mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disc_i | input | 1 | Synchronous discriminator level |
| shutter_i | input | 1 | Acquisition window, high = open |
| mode_i | input | 2 | Counting mode select |
| readout_i | input | 1 | Readout and clear strobe |
| rd_data_o | output | 13 | Counter snapshot {upper, lower} |
| rd_valid_o | output | 1 | High for one cycle after each readout strobe |

## Verification
The bench drives counts to each saturation limit and past it. A design that wraps would read back a small number instead of 31, 255 or 8191. In the joined modes the bench pushes the count across the carry at 32 and right up to the 13-bit limit, which exposes a lower field that saturates on its own or a carry that is lost. It sends hit trains in which later edges must be ignored for time of arrival, opens the shutter while disc_i is already high, and changes mode_i with the shutter open; each of these catches a start that re-triggers, a level taken for an edge, or a mode taken in mid-frame. Back-to-back readouts and a readout with the shutter open check that the clear happens and that counting is held off in the strobe clock.

// File: rtl/hitc_pkg.sv
package hitc_pkg;

  typedef enum logic [1:0] {
    MODE_TOT_TOA  = 2'b00,
    MODE_TOT_EVT  = 2'b01,
    MODE_LONG_TOA = 2'b10,
    MODE_LONG_EVT = 2'b11
  } hitc_mode_e;

  // joined modes chain both counter segments
  function automatic logic mode_is_long(input hitc_mode_e m);
    return m[1];
  endfunction

  // arrival-time modes count every open cycle after the first edge
  function automatic logic mode_is_toa(input hitc_mode_e m);
    return ~m[0];
  endfunction

  // next value of a saturating segment; wrap allowed only when carrying on
  function automatic logic [15:0] seg_next(input logic [15:0] cur,
                                           input int unsigned width,
                                           input logic wrap_ok);
    logic [15:0] top;
    top = 16'((32'd1 << width) - 32'd1);
    if (cur != top) return cur + 16'd1;
    else if (wrap_ok) return 16'd0;
    else return cur;
  endfunction

endpackage

// File: rtl/hitc_edge.sv
module hitc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic disc_i,
  output logic rise_o
);
  logic disc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disc_q <= 1'b0;
    else        disc_q <= disc_i;
  end

  assign rise_o = disc_i & ~disc_q;

  // R3: an edge can never be reported in two consecutive cycles
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/hitc_seg.sv
module hitc_seg #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         wrap_ok_i,
  output logic [W-1:0] val_o,
  output logic         full_o
);
  import hitc_pkg::*;

  logic [15:0] nxt_wide;

  assign nxt_wide = seg_next(16'(val_o), W, wrap_ok_i);
  assign full_o   = &val_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_o <= '0;
    else if (clr_i) val_o <= '0;
    else if (en_i)  val_o <= nxt_wide[W-1:0];
  end

  // R6: a full segment with no carry path stays full
  a_r6_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && en_i && !wrap_ok_i && !clr_i |=> full_o);

  // R6: below the limit an enabled segment steps by exactly one
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !full_o && !clr_i |=> val_o == W'($past(val_o) + 1'b1));

endmodule

// File: rtl/hitc_ctrl.sv
module hitc_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutter_i,
  input  logic [1:0]        mode_i,
  input  logic              readout_i,
  input  logic              disc_i,
  input  logic              rise_i,
  input  logic              lo_full_i,
  input  logic              hi_full_i,
  output logic              lo_en_o,
  output logic              hi_en_o,
  output logic              lo_wrap_o,
  output hitc_pkg::hitc_mode_e mode_o
);
  import hitc_pkg::*;

  hitc_mode_e mode_q;
  logic       toa_run;
  logic       open_win;
  logic       toa_go;
  logic       evt_go;
  logic       tot_go;
  logic       step_go;
  logic       is_long;

  assign open_win = shutter_i & ~readout_i;
  assign is_long  = mode_is_long(mode_q);
  assign toa_go   = open_win & mode_is_toa(mode_q) & (toa_run | rise_i);
  assign evt_go   = open_win & ~mode_is_toa(mode_q) & rise_i;
  assign tot_go   = open_win & disc_i & ~is_long;
  assign step_go  = toa_go | evt_go;

  assign lo_en_o   = is_long ? step_go : tot_go;
  assign hi_en_o   = is_long ? (step_go & lo_full_i) : step_go;
  assign lo_wrap_o = is_long & ~hi_full_i;
  assign mode_o    = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= MODE_TOT_TOA;
    else if (!shutter_i) mode_q <= hitc_mode_e'(mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         toa_run <= 1'b0;
    else if (readout_i) toa_run <= 1'b0;
    else if (toa_go)    toa_run <= 1'b1;
  end

  // R8: an open shutter freezes the registered mode
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_i |=> mode_q == $past(mode_q));

  // R2: once started, arrival timing stays armed until readout
  a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    toa_run && !readout_i |=> toa_run);

endmodule

// File: rtl/pix_hit_counter.sv
module pix_hit_counter #(
  parameter int unsigned LO_W = 5,
  parameter int unsigned HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disc_i,
  input  logic                 shutter_i,
  input  logic [1:0]           mode_i,
  input  logic                 readout_i,
  output logic [LO_W+HI_W-1:0] rd_data_o,
  output logic                 rd_valid_o
);
  import hitc_pkg::*;

  localparam int unsigned TOTAL_W = LO_W + HI_W;

  logic            rise;
  logic            lo_en, hi_en, lo_wrap;
  logic            lo_full, hi_full;
  logic [LO_W-1:0] lo_val;
  logic [HI_W-1:0] hi_val;
  hitc_mode_e      mode_cur;

  hitc_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .disc_i (disc_i),
    .rise_o (rise)
  );

  hitc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .shutter_i (shutter_i),
    .mode_i    (mode_i),
    .readout_i (readout_i),
    .disc_i    (disc_i),
    .rise_i    (rise),
    .lo_full_i (lo_full),
    .hi_full_i (hi_full),
    .lo_en_o   (lo_en),
    .hi_en_o   (hi_en),
    .lo_wrap_o (lo_wrap),
    .mode_o    (mode_cur)
  );

  hitc_seg #(.W(LO_W)) u_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (readout_i),
    .en_i      (lo_en),
    .wrap_ok_i (lo_wrap),
    .val_o     (lo_val),
    .full_o    (lo_full)
  );

  hitc_seg #(.W(HI_W)) u_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (readout_i),
    .en_i      (hi_en),
    .wrap_ok_i (1'b0),
    .val_o     (hi_val),
    .full_o    (hi_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= readout_i;
      if (readout_i) rd_data_o <= TOTAL_W'({hi_val, lo_val});
    end
  end

  // R9: the strobe leaves both counters at zero
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    readout_i |=> (lo_val == '0) && (hi_val == '0));

  // R9: each strobe is followed by a valid flag
  a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
    readout_i |=> rd_valid_o);

  // R7: a closed shutter holds both counters
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shutter_i && !readout_i |=> $stable(lo_val) && $stable(hi_val));

  // R6: in joined modes a full 13-bit value never moves except by clear
  a_r6_joined_sat: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_long(mode_cur) && lo_full && hi_full && !readout_i
    |=> lo_full && hi_full);

endmodule

// File: tb/pix_hit_counter_tb.sv
module pix_hit_counter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disc_i = 1'b0;
  logic        shutter_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        readout_i = 1'b0;
  logic [12:0] rd_data_o;
  logic        rd_valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  int    q_exp[$];
  string q_tag[$];

  // reference state
  int m_lo = 0, m_hi = 0;
  bit m_prev = 0, m_run = 0;
  logic [1:0] m_mode = 2'b00;
  logic [1:0] cur_mode = 2'b00;
  string cur_tag = "R10";

  pix_hit_counter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .disc_i     (disc_i),
    .shutter_i  (shutter_i),
    .mode_i     (mode_i),
    .readout_i  (readout_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  always #4 clk = ~clk;

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock of stimulus plus the reference update for the coming edge
  task automatic cyc(input bit d, input bit sh, input bit rd);
    bit rise;
    int v;
    @(negedge clk);
    disc_i = d; shutter_i = sh; readout_i = rd; mode_i = cur_mode;
    rise = d && !m_prev;
    if (rd) begin
      q_exp.push_back(m_hi * 32 + m_lo);
      q_tag.push_back(cur_tag);
      m_lo = 0; m_hi = 0; m_run = 0;
    end else if (sh) begin
      case (m_mode)
        2'b00: begin
          if (d) m_lo = sat(m_lo + 1, 31);
          if (rise || m_run) begin m_hi = sat(m_hi + 1, 255); m_run = 1; end
        end
        2'b01: begin
          if (d) m_lo = sat(m_lo + 1, 31);
          if (rise) m_hi = sat(m_hi + 1, 255);
        end
        default: begin
          v = m_hi * 32 + m_lo;
          if (m_mode == 2'b10) begin
            if (rise || m_run) begin v = sat(v + 1, 8191); m_run = 1; end
          end else if (rise) v = sat(v + 1, 8191);
          m_hi = v / 32; m_lo = v % 32;
        end
      endcase
    end
    m_prev = d;
    if (!sh) m_mode = cur_mode;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    cur_mode = m;
    idle(2);
  endtask

  task automatic hold(input bit d, input int n);
    for (int i = 0; i < n; i++) cyc(d, 1'b1, 1'b0);
  endtask

  task automatic pulses(input int n, input int hi_len, input int lo_len);
    for (int i = 0; i < n; i++) begin
      hold(1'b1, hi_len);
      hold(1'b0, lo_len);
    end
  endtask

  task automatic read_out(input string tag);
    cur_tag = tag;
    cyc(1'b0, 1'b0, 1'b1);
    idle(2);
  endtask

  // monitor: compare every valid snapshot with the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid_o) begin
        if (q_exp.size() == 0) begin
          check("R9 unexpected valid", 1, 0);
        end else begin
          check(q_tag.pop_front(), int'(rd_data_o), q_exp.pop_front());
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset data", int'(rd_data_o), 0);
    check("R10 reset valid", int'(rd_valid_o), 0);
    read_out("R10 counters zero after reset");

    // mode 00: ToT and arrival time
    set_mode(2'b00);
    hold(1'b0, 3); hold(1'b1, 4); hold(1'b0, 10);
    read_out("R1 R2 tot/toa basic");

    hold(1'b0, 2); pulses(3, 2, 3); hold(1'b0, 5);
    read_out("R2 later edges ignored");

    hold(1'b1, 40); hold(1'b0, 2);
    read_out("R6 R1 tot saturates at 31");

    hold(1'b0, 1); hold(1'b1, 1); hold(1'b0, 300);
    read_out("R6 R2 toa saturates at 255");

    // shutter closed: hits ignored
    for (int i = 0; i < 6; i++) begin cyc(1'b1, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0); end
    read_out("R7 closed shutter ignores hits");

    // mode 01: event counting
    set_mode(2'b01);
    pulses(5, 2, 1);
    read_out("R3 R1 event count");

    cyc(1'b1, 1'b0, 1'b0);
    hold(1'b1, 4); hold(1'b0, 2); pulses(2, 1, 1);
    cyc(1'b0, 1'b0, 1'b0);
    read_out("R3 level at shutter open not an edge");

    pulses(300, 1, 1);
    read_out("R6 R3 event saturates at 255");

    // mode 10: joined arrival time
    set_mode(2'b10);
    hold(1'b0, 2); hold(1'b1, 1); hold(1'b0, 99); pulses(4, 1, 1);
    read_out("R4 joined toa carries");

    hold(1'b1, 1); hold(1'b0, 8300);
    read_out("R6 R4 joined toa saturates at 8191");

    // mode 11: joined events
    set_mode(2'b11);
    pulses(40, 1, 2);
    read_out("R5 joined events carry past 31");

    pulses(8200, 1, 1);
    read_out("R6 R5 joined events saturate at 8191");

    // mode change while open
    set_mode(2'b00);
    hold(1'b0, 2); hold(1'b1, 1);
    cur_mode = 2'b11;
    hold(1'b0, 6); pulses(2, 1, 1);
    cur_mode = 2'b00;
    read_out("R8 mode change ignored while open");

    // back-to-back readouts and readout with shutter open
    set_mode(2'b01);
    pulses(3, 1, 1);
    read_out("R9 first readout");
    read_out("R9 second readout cleared");
    pulses(2, 1, 1);
    cur_tag = "R9 strobe with shutter open";
    cyc(1'b1, 1'b1, 1'b1);
    hold(1'b1, 2); hold(1'b0, 1); hold(1'b1, 1); hold(1'b0, 1);
    read_out("R9 no count in strobe cycle");

    idle(5);
    check("R9 queue drained", q_exp.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule